// File: doc/BRIEF.md
# Burst-of-Two Quad-Data-Rate SRAM Model

This block is a synthesizable model of a static memory with a separate read data port and write data port. A read and a write can run in the same command cycle. Every access moves a burst of two words, one on each half of the command clock. The block has no true dual-edge logic. It runs on a single clock at twice the command rate, and an output flag marks each beat as the rising half (K) or the falling half (K-bar) of the command clock. Read data leaves on the same beat grid, so the K beats stand in for the C clock and the K-bar beats for C-bar.

The two ports share one address bus and use it on opposite beats. The read address is sampled on the K beat that carries the read select, and the write address on the K-bar beat that follows the write select. Storage is two arrays of equal depth, one for the first word of a burst and one for the second, so a burst address names one location in each array. An active-low enable for each 9-bit byte lane travels with every write data word. A separate output-valid flag stands in for the three-state condition of the data outputs.

Top module: `qdrBurst2Sram`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `doutOe` is 0, `dout` is all zeros and `kPhase` is 1.
- R2: `kPhase` is 1 on the first beat after reset and inverts on every later clock, so K beats and K-bar beats alternate.
- R3: If `rdSelN` is 0 on a K beat t, the word in array 0 at `addr` (sampled at t) is driven on `dout` with `doutOe`=1 in beat t+3. The word in array 1 at that address follows in beat t+4.
- R4: If `wrSelN` is 0 on a K beat t, `din`/`bwN` at beat t form word 0 (array 0), and `addr`, `din` and `bwN` at beat t+1 give the write address and word 1 (array 1). The value of `addr` at beat t does not matter.
- R5: `bwN[0]`=0 enables bits 8:0 and `bwN[1]`=0 enables bits 17:9 of the data word on the same beat. A lane whose enable is 1 keeps its stored value.
- R6: `rdSelN` and `wrSelN` are sampled only on K beats. Asserting them on a K-bar beat starts no access.
- R7: When `wrSelN` is 1 on a K beat, `din`, `bwN` and `addr` on that beat and on the next beat change no stored location.
- R8: A read and a write to the same address started on the same K beat return the data stored before that write. The written data is returned by any read started on a later K beat.
- R9: `doutOe` is 0, and `dout` is all zeros, on every beat that carries no read data. Reads on consecutive K beats give an unbroken output stream with no idle beat.
- R10: Word 0 and word 1 at one burst address are stored separately and read back separately.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock, twice the command rate |
| rstN | input | 1 | Active-low synchronous reset |
| kPhase | output | 1 | 1 on K beats, 0 on K-bar beats |
| rdSelN | input | 1 | Active-low read select, sampled on K beats |
| wrSelN | input | 1 | Active-low write select, sampled on K beats |
| addr | input | ADDR_W | Shared address: read address on K, write address on K-bar |
| din | input | BYTE_W*LANES | Write data, one word per beat |
| bwN | input | LANES | Active-low byte-lane write enables, one per lane |
| dout | output | BYTE_W*LANES | Read data, zero when not valid |
| doutOe | output | 1 | High on beats that carry read data |

## Verification
A read command on K beat t is due as word 0 at beat t+3 and word 1 at beat t+4. A write becomes visible to any read whose K beat comes after the write's K-bar address beat. The bench's reference model counts beats from reset release and files each expected output under the beat in which it is due. Outputs are sampled at the falling clock edge of every beat, so the values seen are those registered by the rising edge that opened the beat. At each of these samples the bench checks `kPhase`, `doutOe` and `dout`, and an idle beat is checked for a low `doutOe` and a zero `dout` just as a data beat is checked for its word.

// File: rtl/qdrPkg.sv
package qdrPkg;

  typedef struct packed {
    logic wrCapture;
    logic wrCommit;
    logic rdLatch;
    logic rdFetch;
    logic outWord0;
    logic outWord1;
  } qdrStrobes_t;

endpackage

// File: rtl/qdrCtrl.sv
module qdrCtrl
  import qdrPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdSelN,
  input  logic        wrSelN,
  output logic        kPhase,
  output qdrStrobes_t strb
);

  logic kPhaseQ;
  logic rdP0, rdP1, rdP2;
  logic wrP0;

  // beat phase: K beat first after reset, then alternate
  always_ff @(posedge clk) begin
    if (!rstN) kPhaseQ <= 1'b1;
    else       kPhaseQ <= ~kPhaseQ;
  end

  // command pipeline; selects only count on K beats
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdP0 <= 1'b0;
      rdP1 <= 1'b0;
      rdP2 <= 1'b0;
      wrP0 <= 1'b0;
    end else begin
      rdP0 <= kPhaseQ & ~rdSelN;
      rdP1 <= rdP0;
      rdP2 <= rdP1;
      wrP0 <= kPhaseQ & ~wrSelN;
    end
  end

  always_comb begin
    strb           = '0;
    strb.rdLatch   = kPhaseQ & ~rdSelN;
    strb.wrCapture = kPhaseQ & ~wrSelN;
    strb.rdFetch   = rdP0;
    strb.wrCommit  = wrP0;
    strb.outWord0  = rdP1;
    strb.outWord1  = rdP2;
  end

  assign kPhase = kPhaseQ;

  // R2: phase alternates every beat
  p_phase_toggle_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (kPhaseQ != $past(kPhaseQ)));

  // R6: a fetch always lands on a K-bar beat, so it was issued on a K beat
  p_fetch_kbar_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdP0 |-> !kPhaseQ);

  // R3: word 1 strobe always follows word 0 strobe
  p_word_order_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdP1 |=> rdP2);

endmodule

// File: rtl/qdrBank.sv
module qdrBank #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [LANES-1:0]          be,
  input  logic [ADDR_W-1:0]         wa,
  input  logic [BYTE_W*LANES-1:0]   wd,
  input  logic                      re,
  input  logic [ADDR_W-1:0]         ra,
  output logic [BYTE_W*LANES-1:0]   rd
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W-1:0] store [DEPTH];
    logic [BYTE_W-1:0] rdQ;

    // read-before-write: a same-edge write is not seen by this read
    always_ff @(posedge clk) begin
      if (we && be[l]) store[wa] <= wd[l*BYTE_W +: BYTE_W];
      if (re)          rdQ <= store[ra];
    end

    assign rd[l*BYTE_W +: BYTE_W] = rdQ;
  end

endmodule

// File: rtl/qdrDatapath.sv
module qdrDatapath
  import qdrPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      kPhase,
  input  qdrStrobes_t               strb,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [BYTE_W*LANES-1:0]   din,
  input  logic [LANES-1:0]          bwN,
  output logic [BYTE_W*LANES-1:0]   dout,
  output logic                      doutOe
);

  localparam int DATA_W = BYTE_W * LANES;
  localparam int BANKS  = 2;

  logic [ADDR_W-1:0] rdAddrQ;
  logic [DATA_W-1:0] word0Q;
  logic [LANES-1:0]  word0EnQ;

  logic [DATA_W-1:0] bankWd [BANKS];
  logic [LANES-1:0]  bankBe [BANKS];
  logic [DATA_W-1:0] bankRd [BANKS];

  // capture the read address and the first write word on K beats
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddrQ  <= '0;
      word0Q   <= '0;
      word0EnQ <= '0;
    end else begin
      if (strb.rdLatch) rdAddrQ <= addr;
      if (strb.wrCapture) begin
        word0Q   <= din;
        word0EnQ <= ~bwN;
      end
    end
  end

  assign bankWd[0] = word0Q;
  assign bankBe[0] = word0EnQ;
  assign bankWd[1] = din;
  assign bankBe[1] = ~bwN;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    qdrBank #(
      .ADDR_W (ADDR_W),
      .BYTE_W (BYTE_W),
      .LANES  (LANES)
    ) u_bank (
      .clk (clk),
      .we  (strb.wrCommit),
      .be  (bankBe[b]),
      .wa  (addr),
      .wd  (bankWd[b]),
      .re  (strb.rdFetch),
      .ra  (rdAddrQ),
      .rd  (bankRd[b])
    );
  end

  // output beats: word 0 then word 1, zero and invalid otherwise
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dout   <= '0;
      doutOe <= 1'b0;
    end else if (strb.outWord0) begin
      dout   <= bankRd[0];
      doutOe <= 1'b1;
    end else if (strb.outWord1) begin
      dout   <= bankRd[1];
      doutOe <= 1'b1;
    end else begin
      dout   <= '0;
      doutOe <= 1'b0;
    end
  end

  // R3: a burst output always begins on a K-bar beat
  p_burst_start_kbar_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doutOe) |-> !kPhase);

  // R9: idle output beats carry zero
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !doutOe |-> (dout == '0));

  // R4: a commit is always preceded by a K-beat capture
  p_commit_after_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCommit |-> $past(strb.wrCapture));

endmodule

// File: rtl/qdrBurst2Sram.sv
module qdrBurst2Sram
  import qdrPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  output logic                      kPhase,
  input  logic                      rdSelN,
  input  logic                      wrSelN,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [BYTE_W*LANES-1:0]   din,
  input  logic [LANES-1:0]          bwN,
  output logic [BYTE_W*LANES-1:0]   dout,
  output logic                      doutOe
);

  qdrStrobes_t strb;

  qdrCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .rdSelN (rdSelN),
    .wrSelN (wrSelN),
    .kPhase (kPhase),
    .strb   (strb)
  );

  qdrDatapath #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .LANES  (LANES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .kPhase (kPhase),
    .strb   (strb),
    .addr   (addr),
    .din    (din),
    .bwN    (bwN),
    .dout   (dout),
    .doutOe (doutOe)
  );

endmodule

// File: tb/qdrBurst2Sram_tb.sv
module qdrBurst2Sram_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        kPhase;
  logic        rdSelN = 1'b1;
  logic        wrSelN = 1'b1;
  logic [7:0]  addr = '0;
  logic [17:0] din = '0;
  logic [1:0]  bwN = 2'b11;
  logic [17:0] dout;
  logic        doutOe;

  always #10 clk = ~clk;

  qdrBurst2Sram u_dut (
    .clk    (clk),
    .rstN   (rstN),
    .kPhase (kPhase),
    .rdSelN (rdSelN),
    .wrSelN (wrSelN),
    .addr   (addr),
    .din    (din),
    .bwN    (bwN),
    .dout   (dout),
    .doutOe (doutOe)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  logic [17:0] ref0 [int];
  logic [17:0] ref1 [int];
  logic [17:0] expVal [int];
  string       expTag [int];

  bit          pendW = 0;
  logic [17:0] pendD;
  logic [1:0]  pendBw;

  function automatic logic [17:0] merge(input logic [17:0] old,
                                        input logic [17:0] nw,
                                        input logic [1:0] bwl);
    logic [17:0] r;
    r = old;
    if (!bwl[0]) r[8:0]  = nw[8:0];
    if (!bwl[1]) r[17:9] = nw[17:9];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s beat=%0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  // one beat: check outputs visible now, drive inputs, update model
  task automatic step(input bit rdN, input bit wrN, input int a,
                      input logic [17:0] d, input logic [1:0] bw, input string tag);
    bit ph;
    ph = (cyc % 2 == 0);
    if (cyc == 0) begin
      check(doutOe == 1'b0 && dout == '0, "R1", {13'd0, doutOe, dout}, 32'd0);
      check(kPhase == 1'b1, "R1", {31'd0, kPhase}, 32'd1);
    end else begin
      check(kPhase == ph, "R2", {31'd0, kPhase}, {31'd0, ph});
    end
    if (expTag.exists(cyc)) begin
      check(doutOe == 1'b1, expTag[cyc], {31'd0, doutOe}, 32'd1);
      if (!$isunknown(expVal[cyc]))
        check(dout === expVal[cyc], expTag[cyc], {14'd0, dout}, {14'd0, expVal[cyc]});
    end else if (cyc != 0) begin
      check(doutOe == 1'b0 && dout == '0, "R9", {13'd0, doutOe, dout}, 32'd0);
    end
    rdSelN = rdN;
    wrSelN = wrN;
    addr   = a[7:0];
    din    = d;
    bwN    = bw;
    if (ph) begin
      if (!rdN) begin
        expVal[cyc+3] = ref0.exists(a) ? ref0[a] : 18'hx;
        expVal[cyc+4] = ref1.exists(a) ? ref1[a] : 18'hx;
        expTag[cyc+3] = tag;
        expTag[cyc+4] = tag;
      end
      if (!wrN) begin
        pendW  = 1;
        pendD  = d;
        pendBw = bw;
      end
    end else if (pendW) begin
      ref0[a] = merge(ref0.exists(a) ? ref0[a] : 18'hx, pendD, pendBw);
      ref1[a] = merge(ref1.exists(a) ? ref1[a] : 18'hx, d, bw);
      pendW = 0;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1, 1, 8'h5A, 18'h3FFFF, 2'b00, "");
  endtask

  task automatic wrBurst(input int a, input logic [17:0] d0, input logic [17:0] d1,
                         input logic [1:0] b0, input logic [1:0] b1);
    step(1, 0, 8'hA5, d0, b0, "");
    step(1, 1, a, d1, b1, "");
  endtask

  task automatic rdBurst(input int a, input string tag);
    step(0, 1, a, 18'h0, 2'b11, tag);
    step(1, 1, 8'hA5, 18'h0, 2'b11, tag);
  endtask

  function automatic logic [17:0] pat(input int a, input int w);
    return 18'((a * 1021 + w * 7919 + 5) ^ (w ? 18'h2AAAA : 18'h15555));
  endfunction

  initial begin
    #(20 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog beat=%0d actual=hung expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(doutOe == 1'b0 && dout == '0, "R1", {13'd0, doutOe, dout}, 32'd0);
    rstN = 1'b1;

    // fill with full writes (R4)
    for (int i = 0; i < 16; i++) wrBurst(i, pat(i, 0), pat(i, 1), 2'b00, 2'b00);
    wrBurst(255, pat(255, 0), pat(255, 1), 2'b00, 2'b00);
    idle(2);

    // back-to-back reads, both words independent (R3, R9, R10)
    for (int i = 0; i < 16; i++) rdBurst(i, "R3_R10");
    rdBurst(255, "R10");
    idle(6);

    // byte-lane writes (R5)
    wrBurst(3, 18'h3FFFF, 18'h3FFFF, 2'b10, 2'b01);
    wrBurst(4, 18'h00000, 18'h00000, 2'b11, 2'b11);
    idle(2);
    rdBurst(3, "R5");
    rdBurst(4, "R5");
    idle(6);

    // write port deselected, data and address toggling (R7)
    for (int i = 0; i < 4; i++) step(1, 1, 5, 18'h0F0F0 ^ 18'(i), 2'b00, "");
    rdBurst(5, "R7");
    idle(6);

    // selects on K-bar beats are ignored (R6)
    step(1, 1, 6, 18'h11111, 2'b00, "");
    step(0, 0, 6, 18'h22222, 2'b00, "");
    step(1, 1, 6, 18'h33333, 2'b00, "");
    step(0, 0, 6, 18'h12345, 2'b00, "");
    idle(6);
    rdBurst(6, "R6");
    idle(6);

    // read and write same address same K beat (R8), then new data (R4)
    step(0, 0, 7, 18'h2BEEF, 2'b00, "R8");
    step(1, 1, 7, 18'h1CAFE, 2'b00, "R8");
    rdBurst(7, "R4_R8");
    idle(6);

    // interleaved concurrent reads and writes to other addresses (R3, R4)
    for (int i = 8; i < 12; i++) begin
      step(0, 0, i + 4, pat(i, 2), 2'b00, "R3");
      step(1, 1, i, pat(i, 3), 2'b00, "R3");
    end
    for (int i = 8; i < 12; i++) rdBurst(i, "R4");
    idle(8);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule